// File: doc/BRIEF.md
# Buffered Down-Counting PWM Channel

This block is a single pulse-width-modulation channel built around a down counter that steps once for every cycle in which a tick enable is high. Software-facing logic outside the block holds a count buffer and a compare buffer and presents them on two input buses, together with a four-bit control group. The active counter and the active compare value are separate registers. They take the buffer values only on a manual update or when a period ends with auto-reload set. Buffer values can therefore be changed at any time without disturbing the period in progress.

A channel is brought up in two steps. First the manual-update bit is set with start low, which copies both buffers into the active registers. Then manual-update is cleared while start and auto-reload are set, which begins counting. A count buffer value N gives a period of N+1 ticks. The pin is driven high from the point where the counter reaches the compare value until expiry, and the invert bit flips the pin. Clearing auto-reload stops the channel gracefully: the period in progress finishes and the counter then halts. The start bit keeps the value software wrote.

The decode of the control group has two forms, selected by a parameter. On the last channel of a multi-channel group, auto-reload sits at the position that other channels use for invert, and that channel has no inverter.

Top module: `buffered_pwm_channel`

## Requirements
- R1: After reset the pin is low and the expiry pulse output is low.
- R2: While control bit 1 (manual update) is high, the active counter and compare registers load from the count and compare buffers on each clock, and the counter does not run.
- R3: A low-to-high change of control bit 0 (start), seen while manual update is low, starts the channel. A running counter decreases by one on each clock edge at which the tick enable is high. Clearing manual update while start is already high does not start the channel.
- R4: A count value N gives a period of N+1 ticks. When the counter is at zero on a tick, the expiry output is high for exactly one clock, on the clock after that tick.
- R5: While running, the uninverted level is high when the counter is less than or equal to the compare value and low otherwise, so a compare value C below N gives C+1 high ticks per period.
- R6: A compare value of all ones gives a pin that stays at the active level for the whole period (100 percent duty).
- R7: At expiry with auto-reload set, the counter and compare reload from the buffers. Buffer changes made during a period affect only the following period.
- R8: With auto-reload clear, the channel finishes the current period, pulses expiry once and stops. Start stays set, and setting auto-reload again does not restart the channel until start goes low and then high.
- R9: Control bit 2 (invert) flips the pin, both while running and while stopped. A stopped channel drives the invert bit's value.
- R10: With parameter RELOAD_AT_BIT2 set, auto-reload is read from control bit 2, bit 3 has no effect and the pin is never inverted. With the parameter clear, auto-reload is bit 3.
- R11: Clearing start stops the channel at the next clock, and the pin returns to the idle level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter step enable, one tick per high cycle |
| ctrlNibble | input | 4 | Control group: bit 0 start, bit 1 manual update, bit 2 invert (or auto-reload in the last-channel form), bit 3 auto-reload |
| countBuf | input | CNT_W | Count buffer value N (period N+1 ticks) |
| cmpBuf | input | CNT_W | Compare buffer value |
| pwmOut | output | 1 | PWM pin level |
| expirePulse | output | 1 | One-clock pulse after the counter expires |

## Verification
The bench checks the pin cycle by cycle against the period and duty formulas. A counter that reloaded one tick early or late, or a comparator using strict less-than, would show up there as a wrong period or a high time off by one. Buffer values are rewritten in the middle of a period, so a design that lacked double buffering would shorten the period already in progress. The auto-reload clear case checks that exactly one more expiry follows and that raising auto-reload again with start held high stays silent. A design that stopped at once, or restarted on the level of start rather than its rising edge, fails that case. The last-channel decode form is run with only bit 3 set and then with only bit 2 set, which catches a swapped auto-reload position or an inverter left active on that channel.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadBuf;   // copy buffers into active registers
    logic decr;      // step the counter down
    logic atEnd;     // counter expired on this tick
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startBit,
  input  logic       updBit,
  input  logic       reloadBit,
  input  logic       tickEn,
  input  logic       cntZero,
  output pwmStrobe_t strobe,
  output logic       running,
  output logic       expirePulse
);
  logic startQ;
  logic runQ;
  logic expQ;
  logic stepOk;
  logic runNext;

  always_comb begin
    stepOk        = runQ & tickEn & startBit & ~updBit;
    strobe.atEnd  = stepOk & cntZero;
    strobe.decr   = stepOk & ~cntZero;
    strobe.loadBuf = updBit | (strobe.atEnd & reloadBit);
  end

  always_comb begin
    if (!startBit || updBit)            runNext = 1'b0;
    else if (!startQ)                   runNext = 1'b1;
    else if (strobe.atEnd && !reloadBit) runNext = 1'b0;
    else                                runNext = runQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= 1'b0;
      runQ   <= 1'b0;
      expQ   <= 1'b0;
    end else begin
      startQ <= startBit;
      runQ   <= runNext;
      expQ   <= strobe.atEnd;
    end
  end

  assign running     = runQ;
  assign expirePulse = expQ;
endmodule

// File: rtl/pwm_chan_datapath.sv
module pwm_chan_datapath
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strobe,
  input  logic [CNT_W-1:0] countBuf,
  input  logic [CNT_W-1:0] cmpBuf,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] cmpVal,
  output logic             cntZero,
  output logic             atOrBelow
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cmpQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      cmpQ <= '0;
    end else if (strobe.loadBuf) begin
      cntQ <= countBuf;
      cmpQ <= cmpBuf;
    end else if (strobe.decr) begin
      cntQ <= cntQ - ONE;
    end
  end

  assign cntVal    = cntQ;
  assign cmpVal    = cmpQ;
  assign cntZero   = (cntQ == '0);
  assign atOrBelow = (cntQ <= cmpQ);
endmodule

// File: rtl/buffered_pwm_channel.sv
module buffered_pwm_channel
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W          = 16,
  parameter bit RELOAD_AT_BIT2 = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic [3:0]       ctrlNibble,
  input  logic [CNT_W-1:0] countBuf,
  input  logic [CNT_W-1:0] cmpBuf,
  output logic             pwmOut,
  output logic             expirePulse
);
  localparam int START_POS = 0;
  localparam int UPD_POS   = 1;

  logic             startBit;
  logic             updBit;
  logic             reloadBit;
  logic             invBit;
  logic             running;
  logic             cntZero;
  logic             atOrBelow;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] cmpVal;
  pwmStrobe_t       strobe;

  assign startBit = ctrlNibble[START_POS];
  assign updBit   = ctrlNibble[UPD_POS];

  generate
    if (RELOAD_AT_BIT2) begin : g_lastGroup
      assign reloadBit = ctrlNibble[2];
      assign invBit    = 1'b0;
    end else begin : g_normalGroup
      assign reloadBit = ctrlNibble[3];
      assign invBit    = ctrlNibble[2];
    end
  endgenerate

  pwm_chan_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startBit   (startBit),
    .updBit     (updBit),
    .reloadBit  (reloadBit),
    .tickEn     (tickEn),
    .cntZero    (cntZero),
    .strobe     (strobe),
    .running    (running),
    .expirePulse(expirePulse)
  );

  pwm_chan_datapath #(.CNT_W(CNT_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .countBuf (countBuf),
    .cmpBuf   (cmpBuf),
    .cntVal   (cntVal),
    .cmpVal   (cmpVal),
    .cntZero  (cntZero),
    .atOrBelow(atOrBelow)
  );

  assign pwmOut = (running & atOrBelow) ^ invBit;
endmodule

// File: rtl/pwm_chan_checker.sv
module pwm_chan_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             startBit,
  input logic             updBit,
  input logic             reloadBit,
  input logic             invBit,
  input logic             running,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] cmpVal,
  input logic [CNT_W-1:0] countBuf,
  input logic             pwmOut,
  input logic             expirePulse
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic stepAtEnd;
  assign stepAtEnd = running && tickEn && startBit && !updBit && (cntVal == '0);

  AST_UPDATE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    updBit |=> (!running && cntVal == $past(countBuf)));  // R2

  AST_TICK_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (running && tickEn && startBit && !updBit && cntVal != '0)
      |=> (cntVal == $past(cntVal) - ONE));  // R3

  AST_EXPIRE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse |-> $past(stepAtEnd));  // R4

  AST_RELOAD_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    (stepAtEnd && reloadBit) |=> (running && cntVal == $past(countBuf)));  // R7

  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    (stepAtEnd && !reloadBit) |=> !running);  // R8

  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    (running && cmpVal == ALL_ONES) |-> (pwmOut != invBit));  // R6

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (pwmOut == invBit));  // R9

  AST_START_CLEAR_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    !startBit |=> !running);  // R11
endmodule

bind buffered_pwm_channel pwm_chan_checker #(.CNT_W(CNT_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .tickEn     (tickEn),
  .startBit   (startBit),
  .updBit     (updBit),
  .reloadBit  (reloadBit),
  .invBit     (invBit),
  .running    (running),
  .cntVal     (cntVal),
  .cmpVal     (cmpVal),
  .countBuf   (countBuf),
  .pwmOut     (pwmOut),
  .expirePulse(expirePulse)
);

// File: tb/sim_buffered_pwm_channel.sv
`timescale 1ns/1ps
module sim_buffered_pwm_channel;
  localparam logic [3:0] B_START = 4'b0001;
  localparam logic [3:0] B_UPD   = 4'b0010;
  localparam logic [3:0] B_INV   = 4'b0100;
  localparam logic [3:0] B_AR    = 4'b1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b1;
  logic        slowTick = 1'b0;
  logic [3:0]  ctrl0 = 4'b0;
  logic [3:0]  ctrl1 = 4'b0;
  logic [15:0] countBuf = 16'd0;
  logic [15:0] cmpBuf = 16'd0;
  logic        out0, exp0, out1, exp1;
  int          checks = 0;
  int          failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  buffered_pwm_channel #(.CNT_W(16), .RELOAD_AT_BIT2(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ctrlNibble(ctrl0),
    .countBuf(countBuf), .cmpBuf(cmpBuf), .pwmOut(out0), .expirePulse(exp0));

  buffered_pwm_channel #(.CNT_W(16), .RELOAD_AT_BIT2(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ctrlNibble(ctrl1),
    .countBuf(countBuf), .cmpBuf(cmpBuf), .pwmOut(out1), .expirePulse(exp1));

  task automatic step();
    @(negedge clk);
    tickEn = slowTick ? ~tickEn : 1'b1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // manual update then arm start with auto-reload
  task automatic load0(input int n, input int c, input logic [3:0] inv);
    ctrl0 = inv; countBuf = 16'(n); cmpBuf = 16'(c);
    step();
    ctrl0 = B_UPD | inv;
    step();
    chk("R2 halted while updating", {31'd0, out0}, {31'd0, inv[2]});
    ctrl0 = B_START | B_AR | inv;
  endtask

  task automatic t_reset();
    chk("R1 pin after reset", {31'd0, out0}, 32'd0);
    chk("R1 expiry after reset", {31'd0, exp0}, 32'd0);
  endtask

  task automatic t_pattern(input int n, input int c, input logic [3:0] inv, input string req);
    load0(n, c, inv);
    for (int k = 0; k < 2 * (n + 1); k++) begin
      int phase;
      int cntE;
      logic hi;
      step();
      phase = k % (n + 1);
      cntE = n - phase;
      hi = (c >= 16'hFFFF) ? 1'b1 : (cntE <= c);
      chk({req, " R5 pin level"}, {31'd0, out0}, {31'd0, hi ^ inv[2]});
      chk("R4 expiry timing", {31'd0, exp0}, {31'd0, (k > 0 && phase == 0)});
    end
    ctrl0 = inv;
    step();
    chk("R9 idle level after stop", {31'd0, out0}, {31'd0, inv[2]});
  endtask

  task automatic t_slow_tick();
    int waitCnt = 0;
    int gap = 0;
    slowTick = 1'b1;
    load0(3, 1, 4'b0);
    while (!exp0 && waitCnt < 50) begin step(); waitCnt++; end
    step();
    chk("R4 pulse one clock wide", {31'd0, exp0}, 32'd0);
    gap = 1;
    while (!exp0 && gap < 50) begin step(); gap++; end
    chk("R3 R4 period with half-rate tick", gap, 8);
    slowTick = 1'b0;
    ctrl0 = 4'b0;
    step();
  endtask

  task automatic t_buffer_change();
    int hiA = 0;
    int hiB = 0;
    load0(5, 2, 4'b0);
    for (int k = 0; k < 12; k++) begin
      step();
      if (k < 6 && out0) hiA++;
      if (k >= 6 && k < 10 && out0) hiB++;
      chk("R7 expiry after buffer change", {31'd0, exp0}, {31'd0, (k == 6 || k == 10)});
      if (k == 2) begin countBuf = 16'd3; cmpBuf = 16'd0; end
    end
    chk("R7 current period kept old compare", hiA, 3);
    chk("R7 next period uses new compare", hiB, 1);
    ctrl0 = 4'b0;
    step();
  endtask

  task automatic t_graceful_stop();
    int pulses = 0;
    load0(3, 0, 4'b0);
    for (int k = 0; k < 6; k++) step();
    ctrl0 = B_START;
    for (int k = 0; k < 12; k++) begin step(); if (exp0) pulses++; end
    chk("R8 one final expiry", pulses, 1);
    chk("R8 stopped pin idle", {31'd0, out0}, 32'd0);
    pulses = 0;
    ctrl0 = B_START | B_AR;
    for (int k = 0; k < 12; k++) begin step(); if (exp0) pulses++; end
    chk("R8 no restart without start edge", pulses, 0);
    ctrl0 = 4'b0;
    step();
    ctrl0 = B_START | B_AR;
    pulses = 0;
    for (int k = 0; k < 12; k++) begin step(); if (exp0) pulses++; end
    chk("R8 restart on start edge", pulses, 3);
    ctrl0 = 4'b0;
    step();
  endtask

  task automatic t_start_clear();
    int pulses = 0;
    load0(7, 3, 4'b0);
    for (int k = 0; k < 5; k++) step();
    chk("R5 high at compare match", {31'd0, out0}, 32'd1);
    ctrl0 = B_AR;
    step();
    chk("R11 pin idle after start clear", {31'd0, out0}, 32'd0);
    for (int k = 0; k < 10; k++) begin step(); if (exp0) pulses++; end
    chk("R11 no expiry after start clear", pulses, 0);
    ctrl0 = 4'b0;
    step();
  endtask

  task automatic t_last_group();
    int pulses = 0;
    countBuf = 16'd2; cmpBuf = 16'd0;
    ctrl1 = 4'b0; step();
    ctrl1 = B_UPD; step();
    ctrl1 = B_START | 4'b1000;  // bit 3 only: no auto-reload here
    for (int k = 0; k < 9; k++) begin step(); if (exp1) pulses++; end
    chk("R10 bit3 ignored, single period", pulses, 1);
    ctrl1 = 4'b0; step();
    ctrl1 = B_UPD; step();
    ctrl1 = B_START | 4'b0100;  // bit 2 is auto-reload here
    pulses = 0;
    for (int k = 0; k < 9; k++) begin
      step();
      if (exp1) pulses++;
      if (k == 0) chk("R10 pin not inverted", {31'd0, out1}, 32'd0);
      if (k == 2) chk("R10 pin high at match", {31'd0, out1}, 32'd1);
    end
    chk("R10 bit2 auto-reload keeps running", pulses, 2);
    ctrl1 = 4'b0;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    t_reset();
    t_pattern(4, 1, 4'b0, "R3");
    t_pattern(6, 0, 4'b0, "R3");
    t_pattern(4, 1, B_INV, "R9");
    t_pattern(3, 16'hFFFF, 4'b0, "R6");
    t_slow_tick();
    t_buffer_change();
    t_graceful_stop();
    t_start_clear();
    t_last_group();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule